// File: doc/BRIEF.md
# Memory dependence issue scheduler

This block sits beside the issue stage of an out-of-order core and holds every in-flight load and store until it may be sent to memory. When an instruction is inserted, the block asks an external dependence predictor which older store, if any, it is likely to read from or overwrite. An instruction with a predicted producer waits until that store issues. An instruction without one waits only for its operands.

Each waiting entry carries two readiness flags, one for operands and one for memory ordering. It moves to the ready pool only when both are set. A wake from an issuing store sets the memory flag of all entries linked to that store. An operands-ready notification sets the operand flag. Non-speculative entries ignore both flags and leave the waiting pool only on an explicit release. The issue port always offers the oldest ready entry. A squash removes everything younger than a given sequence number. Insert, issue, squash and violation events are forwarded to the predictor in the cycle they happen, and four counters keep statistics on inserted and conflicting accesses.

Top module: `memdep_sched`

## Requirements
- R1: After reset no entry is held: `iss_valid` and `full` are 0 and all four counters read 0.
- R2: On an accepted insert the block drives `pred_lookup_pc` with `ins_pc` and reads `pred_lookup_store` in the same cycle. A value of 0, or a sequence number of a store that is not tracked, means no dependence. An entry with no dependence, `ins_ops_ready`=1 and `ins_nonspec`=0 is offered on the issue port in the cycle after the insert.
- R3: `iss_valid` is 1 whenever the ready pool is not empty and no squash is present, and `iss_seq` is then the smallest sequence number in it. An issue fires when `iss_valid` and `iss_ready` are both 1. The entry is removed, and `pred_iss_*` carry its PC, sequence number and store flag in that cycle.
- R4: An entry with a dependence waits. When its store issues, the entry becomes ready if its operands are ready, so it is offered in the cycle after the store issues. Otherwise its memory flag is set and it waits for operands.
- R5: An operands-ready notification (`opr_valid`, `opr_seq`) moves a waiting, speculative entry whose memory flag is set to the ready pool. A notification naming no waiting entry changes nothing.
- R6: An accepted store insert (`ins_is_store`=1) raises `pred_reg_valid` with its PC and sequence number in the same cycle. The store stays tracked as a producer until it issues or is squashed. A load insert never raises `pred_reg_valid`.
- R7: A non-speculative entry (`ins_nonspec`=1) is inserted with no dependence. It becomes ready only on a release (`rel_valid`, `rel_seq`), whatever operand notifications it receives.
- R8: A squash (`sq_valid`, `sq_seq`=N) removes every entry and tracked store whose sequence number is greater than N. It is forwarded on `pred_sq_*` in the same cycle. In the squash cycle `iss_valid` is 0, `full` is 1, and insert, operand and release inputs are ignored.
- R9: A violation report (`viol_valid` with load and store PCs) appears unchanged on `pred_viol_*` in the same cycle.
- R10: Each accepted load insert adds one to `cnt_ins_loads`, and each accepted store insert adds one to `cnt_ins_stores`. Each accepted insert with a dependence adds one to `cnt_conf_loads` or to `cnt_conf_stores`, according to its type.
- R11: `full` is 1 when all entries are occupied or all store trackers are in use. An insert presented while `full` is 1 is ignored.
- R12: If an insert predicts a producer store that issues in that same cycle, the inserted entry is treated as having no dependence and is not counted as conflicting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ins_valid | input | 1 | Insert request |
| ins_seq | input | SEQ_W | Sequence number of inserted instruction (nonzero) |
| ins_pc | input | PC_W | PC of inserted instruction |
| ins_is_store | input | 1 | 1 = store, 0 = load |
| ins_ops_ready | input | 1 | Operands already available at insert |
| ins_nonspec | input | 1 | Entry may only leave waiting on release |
| full | output | 1 | Insert is not accepted this cycle |
| pred_lookup_pc | output | PC_W | PC sent to the predictor lookup |
| pred_lookup_store | input | SEQ_W | Predicted producer store sequence, 0 = none |
| pred_reg_valid | output | 1 | Store registration to the predictor |
| pred_reg_pc | output | PC_W | Registered store PC |
| pred_reg_seq | output | SEQ_W | Registered store sequence number |
| opr_valid | input | 1 | Operands-ready notification |
| opr_seq | input | SEQ_W | Entry whose operands are ready |
| rel_valid | input | 1 | Release of a non-speculative entry |
| rel_seq | input | SEQ_W | Entry to release |
| iss_ready | input | 1 | Consumer accepts an issue |
| iss_valid | output | 1 | A ready entry is offered |
| iss_seq | output | SEQ_W | Sequence number of offered entry |
| iss_pc | output | PC_W | PC of offered entry |
| iss_is_store | output | 1 | Offered entry is a store |
| pred_iss_valid | output | 1 | Issue notification to the predictor |
| pred_iss_pc | output | PC_W | PC of issued entry |
| pred_iss_seq | output | SEQ_W | Sequence number of issued entry |
| pred_iss_store | output | 1 | Issued entry is a store |
| sq_valid | input | 1 | Squash request |
| sq_seq | input | SEQ_W | Youngest surviving sequence number |
| pred_sq_valid | output | 1 | Squash forwarded to the predictor |
| pred_sq_seq | output | SEQ_W | Forwarded squash number |
| viol_valid | input | 1 | Ordering violation report |
| viol_load_pc | input | PC_W | PC of violating load |
| viol_store_pc | input | PC_W | PC of the store it bypassed |
| pred_viol_valid | output | 1 | Violation forwarded to the predictor |
| pred_viol_load_pc | output | PC_W | Forwarded load PC |
| pred_viol_store_pc | output | PC_W | Forwarded store PC |
| cnt_ins_loads | output | CNT_W | Inserted loads |
| cnt_ins_stores | output | CNT_W | Inserted stores |
| cnt_conf_loads | output | CNT_W | Loads inserted with a dependence |
| cnt_conf_stores | output | CNT_W | Stores inserted with a dependence |

## Verification
Predictor lookups, registrations, issue notifications, squash and violation forwarding are combinational and are due in the cycle of their stimulus. The bench checks them one time unit after it drives the inputs at the falling edge, before the capturing edge. Pool changes are registered, so a new ready entry, a wake-up or a squash shows on the issue port and `full` one cycle after the edge that caused it, and those checks sample at the next falling edge. A scoreboard queue holds the expected issue order. A monitor pops it at each falling edge where `iss_valid` and `iss_ready` are both high, so an entry that issues late, early, out of order or twice shows up as a mismatch, an unexpected issue or a leftover item.

// File: rtl/memdep_pkg.sv
package memdep_pkg;

    typedef enum logic [1:0] {
        SLOT_FREE  = 2'd0,
        SLOT_WAIT  = 2'd1,
        SLOT_READY = 2'd2
    } slot_state_e;

    typedef struct packed {
        logic ops_rdy;
        logic mem_rdy;
        logic nonspec;
        logic has_dep;
    } wait_flags_t;

    // A speculative waiting entry leaves once both readiness flags hold.
    function automatic logic may_leave_wait(input wait_flags_t f);
        return !f.nonspec && f.ops_rdy && f.mem_rdy;
    endfunction

endpackage

// File: rtl/memdep_first_free.sv
module memdep_first_free #(
    parameter int N  = 16,
    parameter int IW = $clog2(N)
) (
    input  logic [N-1:0]  busy,
    output logic          found,
    output logic [IW-1:0] idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (!busy[i]) begin
                found = 1'b1;
                idx   = IW'(i);
            end
        end
    end
endmodule

// File: rtl/memdep_oldest_pick.sv
module memdep_oldest_pick #(
    parameter int N     = 16,
    parameter int SEQ_W = 16,
    parameter int IW    = $clog2(N)
) (
    input  logic [N-1:0]     req,
    input  logic [SEQ_W-1:0] seq [N],
    output logic             found,
    output logic [IW-1:0]    idx
);
    logic [SEQ_W-1:0] best;

    always_comb begin
        found = 1'b0;
        idx   = '0;
        best  = '0;
        for (int i = 0; i < N; i++) begin
            if (req[i] && (!found || seq[i] < best)) begin
                found = 1'b1;
                idx   = IW'(i);
                best  = seq[i];
            end
        end
    end
endmodule

// File: rtl/memdep_store_tab.sv
module memdep_store_tab #(
    parameter int STORES = 8,
    parameter int SEQ_W  = 16,
    parameter int SIW    = $clog2(STORES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [SEQ_W-1:0] lookup_seq,
    output logic             hit,
    output logic [SIW-1:0]   hit_idx,
    input  logic             alloc_en,
    input  logic [SEQ_W-1:0] alloc_seq,
    output logic [SIW-1:0]   alloc_idx,
    output logic             tab_full,
    input  logic             free_en,
    input  logic [SIW-1:0]   free_idx,
    input  logic             sq_en,
    input  logic [SEQ_W-1:0] sq_seq
);
    logic [STORES-1:0] live_q;
    logic [SEQ_W-1:0]  seq_q [STORES];
    logic              any_free;

    memdep_first_free #(.N(STORES), .IW(SIW)) u_free (
        .busy  (live_q),
        .found (any_free),
        .idx   (alloc_idx)
    );

    assign tab_full = !any_free;

    always_comb begin
        hit     = 1'b0;
        hit_idx = '0;
        for (int i = 0; i < STORES; i++) begin
            if (live_q[i] && lookup_seq != '0 && seq_q[i] == lookup_seq) begin
                hit     = 1'b1;
                hit_idx = SIW'(i);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            live_q <= '0;
            for (int i = 0; i < STORES; i++) seq_q[i] <= '0;
        end else if (sq_en) begin
            for (int i = 0; i < STORES; i++)
                if (seq_q[i] > sq_seq) live_q[i] <= 1'b0;
        end else begin
            for (int i = 0; i < STORES; i++) begin
                if (alloc_en && alloc_idx == SIW'(i)) begin
                    live_q[i] <= 1'b1;
                    seq_q[i]  <= alloc_seq;
                end else if (free_en && free_idx == SIW'(i)) begin
                    live_q[i] <= 1'b0;
                end
            end
        end
    end
endmodule

// File: rtl/memdep_sched.sv
module memdep_sched
    import memdep_pkg::*;
#(
    parameter int ENTRIES = 16,
    parameter int STORES  = 8,
    parameter int SEQ_W   = 16,
    parameter int PC_W    = 32,
    parameter int CNT_W   = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ins_valid,
    input  logic [SEQ_W-1:0] ins_seq,
    input  logic [PC_W-1:0]  ins_pc,
    input  logic             ins_is_store,
    input  logic             ins_ops_ready,
    input  logic             ins_nonspec,
    output logic             full,
    output logic [PC_W-1:0]  pred_lookup_pc,
    input  logic [SEQ_W-1:0] pred_lookup_store,
    output logic             pred_reg_valid,
    output logic [PC_W-1:0]  pred_reg_pc,
    output logic [SEQ_W-1:0] pred_reg_seq,
    input  logic             opr_valid,
    input  logic [SEQ_W-1:0] opr_seq,
    input  logic             rel_valid,
    input  logic [SEQ_W-1:0] rel_seq,
    input  logic             iss_ready,
    output logic             iss_valid,
    output logic [SEQ_W-1:0] iss_seq,
    output logic [PC_W-1:0]  iss_pc,
    output logic             iss_is_store,
    output logic             pred_iss_valid,
    output logic [PC_W-1:0]  pred_iss_pc,
    output logic [SEQ_W-1:0] pred_iss_seq,
    output logic             pred_iss_store,
    input  logic             sq_valid,
    input  logic [SEQ_W-1:0] sq_seq,
    output logic             pred_sq_valid,
    output logic [SEQ_W-1:0] pred_sq_seq,
    input  logic             viol_valid,
    input  logic [PC_W-1:0]  viol_load_pc,
    input  logic [PC_W-1:0]  viol_store_pc,
    output logic             pred_viol_valid,
    output logic [PC_W-1:0]  pred_viol_load_pc,
    output logic [PC_W-1:0]  pred_viol_store_pc,
    output logic [CNT_W-1:0] cnt_ins_loads,
    output logic [CNT_W-1:0] cnt_ins_stores,
    output logic [CNT_W-1:0] cnt_conf_loads,
    output logic [CNT_W-1:0] cnt_conf_stores
);
    localparam int EIW = $clog2(ENTRIES);
    localparam int SIW = $clog2(STORES);

    // Entry storage
    slot_state_e      st_q   [ENTRIES];
    wait_flags_t      flg_q  [ENTRIES];
    logic [SEQ_W-1:0] seq_q  [ENTRIES];
    logic [PC_W-1:0]  pc_q   [ENTRIES];
    logic             isst_q [ENTRIES];
    logic [SIW-1:0]   own_q  [ENTRIES];   // tracker held by a store entry
    logic [SIW-1:0]   dep_q  [ENTRIES];   // tracker of the predicted producer

    logic [ENTRIES-1:0] busy_v, ready_v;
    logic               ent_found, pick_found;
    logic [EIW-1:0]     ent_idx, pick_idx;

    logic               tab_hit, tab_full;
    logic [SIW-1:0]     tab_hit_idx, tab_alloc_idx;

    logic               ins_go, iss_fire, st_fire, dep_ok;
    logic [SIW-1:0]     st_fire_slot;

    always_comb begin
        for (int i = 0; i < ENTRIES; i++) begin
            busy_v[i]  = (st_q[i] != SLOT_FREE);
            ready_v[i] = (st_q[i] == SLOT_READY);
        end
    end

    memdep_first_free #(.N(ENTRIES), .IW(EIW)) u_ent_free (
        .busy  (busy_v),
        .found (ent_found),
        .idx   (ent_idx)
    );

    memdep_oldest_pick #(.N(ENTRIES), .SEQ_W(SEQ_W), .IW(EIW)) u_pick (
        .req   (ready_v),
        .seq   (seq_q),
        .found (pick_found),
        .idx   (pick_idx)
    );

    memdep_store_tab #(.STORES(STORES), .SEQ_W(SEQ_W), .SIW(SIW)) u_stab (
        .clk        (clk),
        .rst        (rst),
        .lookup_seq (pred_lookup_store),
        .hit        (tab_hit),
        .hit_idx    (tab_hit_idx),
        .alloc_en   (pred_reg_valid),
        .alloc_seq  (ins_seq),
        .alloc_idx  (tab_alloc_idx),
        .tab_full   (tab_full),
        .free_en    (st_fire),
        .free_idx   (st_fire_slot),
        .sq_en      (sq_valid),
        .sq_seq     (sq_seq)
    );

    // Edge handshakes and predictor-side forwarding
    assign full           = !ent_found || tab_full || sq_valid;
    assign ins_go         = ins_valid && !full;
    assign iss_valid      = pick_found && !sq_valid;
    assign iss_seq        = seq_q[pick_idx];
    assign iss_pc         = pc_q[pick_idx];
    assign iss_is_store   = isst_q[pick_idx];
    assign iss_fire       = iss_valid && iss_ready;
    assign st_fire        = iss_fire && isst_q[pick_idx];
    assign st_fire_slot   = own_q[pick_idx];

    // A producer that leaves in this very cycle cannot wake a newcomer later.
    assign dep_ok = tab_hit && !ins_nonspec && !(st_fire && tab_hit_idx == st_fire_slot);

    assign pred_lookup_pc     = ins_pc;
    assign pred_reg_valid     = ins_go && ins_is_store;
    assign pred_reg_pc        = ins_pc;
    assign pred_reg_seq       = ins_seq;
    assign pred_iss_valid     = iss_fire;
    assign pred_iss_pc        = iss_pc;
    assign pred_iss_seq       = iss_seq;
    assign pred_iss_store     = iss_is_store;
    assign pred_sq_valid      = sq_valid;
    assign pred_sq_seq        = sq_seq;
    assign pred_viol_valid    = viol_valid;
    assign pred_viol_load_pc  = viol_load_pc;
    assign pred_viol_store_pc = viol_store_pc;

    // Per-entry next state
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < ENTRIES; i++) begin
                st_q[i]   <= SLOT_FREE;
                flg_q[i]  <= '0;
                seq_q[i]  <= '0;
                pc_q[i]   <= '0;
                isst_q[i] <= 1'b0;
                own_q[i]  <= '0;
                dep_q[i]  <= '0;
            end
        end else if (sq_valid) begin
            for (int i = 0; i < ENTRIES; i++)
                if (st_q[i] != SLOT_FREE && seq_q[i] > sq_seq) st_q[i] <= SLOT_FREE;
        end else begin
            for (int i = 0; i < ENTRIES; i++) begin
                wait_flags_t nf;
                nf = flg_q[i];
                if (ins_go && ent_idx == EIW'(i)) begin
                    seq_q[i]   <= ins_seq;
                    pc_q[i]    <= ins_pc;
                    isst_q[i]  <= ins_is_store;
                    own_q[i]   <= tab_alloc_idx;
                    dep_q[i]   <= tab_hit_idx;
                    nf.ops_rdy = ins_ops_ready;
                    nf.mem_rdy = !dep_ok;
                    nf.nonspec = ins_nonspec;
                    nf.has_dep = dep_ok;
                    flg_q[i]   <= nf;
                    st_q[i]    <= may_leave_wait(nf) ? SLOT_READY : SLOT_WAIT;
                end else if (st_q[i] == SLOT_READY) begin
                    if (iss_fire && pick_idx == EIW'(i)) st_q[i] <= SLOT_FREE;
                end else if (st_q[i] == SLOT_WAIT) begin
                    if (opr_valid && opr_seq == seq_q[i]) nf.ops_rdy = 1'b1;
                    if (st_fire && nf.has_dep && dep_q[i] == st_fire_slot) begin
                        nf.mem_rdy = 1'b1;
                        nf.has_dep = 1'b0;
                    end
                    flg_q[i] <= nf;
                    if (nf.nonspec) begin
                        if (rel_valid && rel_seq == seq_q[i]) st_q[i] <= SLOT_READY;
                    end else if (may_leave_wait(nf)) begin
                        st_q[i] <= SLOT_READY;
                    end
                end
            end
        end
    end

    // Statistics
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_ins_loads   <= '0;
            cnt_ins_stores  <= '0;
            cnt_conf_loads  <= '0;
            cnt_conf_stores <= '0;
        end else if (ins_go) begin
            if (ins_is_store) begin
                cnt_ins_stores <= cnt_ins_stores + CNT_W'(1);
                if (dep_ok) cnt_conf_stores <= cnt_conf_stores + CNT_W'(1);
            end else begin
                cnt_ins_loads <= cnt_ins_loads + CNT_W'(1);
                if (dep_ok) cnt_conf_loads <= cnt_conf_loads + CNT_W'(1);
            end
        end
    end
endmodule

// File: rtl/memdep_sched_chk.sv
module memdep_sched_chk #(
    parameter int SEQ_W = 16,
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             ins_valid,
    input logic             ins_is_store,
    input logic             full,
    input logic             pred_reg_valid,
    input logic             iss_valid,
    input logic             iss_ready,
    input logic [SEQ_W-1:0] iss_seq,
    input logic             sq_valid,
    input logic [SEQ_W-1:0] sq_seq,
    input logic [CNT_W-1:0] cnt_ins_loads,
    input logic [CNT_W-1:0] cnt_ins_stores
);
    // R3: an issued entry is gone on the next cycle
    a_r3_issued_removed: assert property (@(posedge clk) disable iff (rst)
        (iss_valid && iss_ready) |=> !(iss_valid && iss_seq == $past(iss_seq)));

    // R8: nothing is offered while a squash is present
    a_r8_no_issue_in_squash: assert property (@(posedge clk) disable iff (rst)
        sq_valid |-> !iss_valid);

    // R8: no younger entry survives a squash
    a_r8_squash_clears_young: assert property (@(posedge clk) disable iff (rst)
        sq_valid |=> !(iss_valid && iss_seq > $past(sq_seq)));

    // R6: registration only for an accepted store
    a_r6_register_only_store: assert property (@(posedge clk) disable iff (rst)
        pred_reg_valid |-> (ins_valid && ins_is_store && !full));

    // R10: insert counters step by at most one
    a_r10_counter_step: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((cnt_ins_loads - $past(cnt_ins_loads)) <= CNT_W'(1) &&
                  (cnt_ins_stores - $past(cnt_ins_stores)) <= CNT_W'(1)));

    // R11: no insert is taken while full
    a_r11_full_blocks_insert: assert property (@(posedge clk) disable iff (rst)
        full |=> (cnt_ins_loads == $past(cnt_ins_loads) &&
                  cnt_ins_stores == $past(cnt_ins_stores)));
endmodule

bind memdep_sched memdep_sched_chk #(.SEQ_W(SEQ_W), .CNT_W(CNT_W)) u_chk (
    .clk            (clk),
    .rst            (rst),
    .ins_valid      (ins_valid),
    .ins_is_store   (ins_is_store),
    .full           (full),
    .pred_reg_valid (pred_reg_valid),
    .iss_valid      (iss_valid),
    .iss_ready      (iss_ready),
    .iss_seq        (iss_seq),
    .sq_valid       (sq_valid),
    .sq_seq         (sq_seq),
    .cnt_ins_loads  (cnt_ins_loads),
    .cnt_ins_stores (cnt_ins_stores)
);

// File: tb/sim_memdep_sched.sv
`timescale 1ns/1ps
module sim_memdep_sched;
    localparam int SEQ_W = 16;
    localparam int PC_W  = 32;
    localparam int CNT_W = 16;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    logic             ins_valid = 0, ins_is_store = 0, ins_ops_ready = 0, ins_nonspec = 0;
    logic [SEQ_W-1:0] ins_seq = '0, pred_lookup_store = '0, opr_seq = '0, rel_seq = '0, sq_seq = '0;
    logic [PC_W-1:0]  ins_pc = '0, viol_load_pc = '0, viol_store_pc = '0;
    logic             opr_valid = 0, rel_valid = 0, iss_ready = 0, sq_valid = 0, viol_valid = 0;
    logic             full, pred_reg_valid, iss_valid, iss_is_store, pred_iss_valid, pred_iss_store;
    logic             pred_sq_valid, pred_viol_valid;
    logic [PC_W-1:0]  pred_lookup_pc, pred_reg_pc, iss_pc, pred_iss_pc, pred_viol_load_pc, pred_viol_store_pc;
    logic [SEQ_W-1:0] pred_reg_seq, iss_seq, pred_iss_seq, pred_sq_seq;
    logic [CNT_W-1:0] cnt_ins_loads, cnt_ins_stores, cnt_conf_loads, cnt_conf_stores;

    memdep_sched u0 (
        .clk(clk), .rst(rst),
        .ins_valid(ins_valid), .ins_seq(ins_seq), .ins_pc(ins_pc), .ins_is_store(ins_is_store),
        .ins_ops_ready(ins_ops_ready), .ins_nonspec(ins_nonspec), .full(full),
        .pred_lookup_pc(pred_lookup_pc), .pred_lookup_store(pred_lookup_store),
        .pred_reg_valid(pred_reg_valid), .pred_reg_pc(pred_reg_pc), .pred_reg_seq(pred_reg_seq),
        .opr_valid(opr_valid), .opr_seq(opr_seq), .rel_valid(rel_valid), .rel_seq(rel_seq),
        .iss_ready(iss_ready), .iss_valid(iss_valid), .iss_seq(iss_seq), .iss_pc(iss_pc),
        .iss_is_store(iss_is_store), .pred_iss_valid(pred_iss_valid), .pred_iss_pc(pred_iss_pc),
        .pred_iss_seq(pred_iss_seq), .pred_iss_store(pred_iss_store),
        .sq_valid(sq_valid), .sq_seq(sq_seq), .pred_sq_valid(pred_sq_valid), .pred_sq_seq(pred_sq_seq),
        .viol_valid(viol_valid), .viol_load_pc(viol_load_pc), .viol_store_pc(viol_store_pc),
        .pred_viol_valid(pred_viol_valid), .pred_viol_load_pc(pred_viol_load_pc),
        .pred_viol_store_pc(pred_viol_store_pc),
        .cnt_ins_loads(cnt_ins_loads), .cnt_ins_stores(cnt_ins_stores),
        .cnt_conf_loads(cnt_conf_loads), .cnt_conf_stores(cnt_conf_stores)
    );

    int checks = 0, fails = 0;
    int exp_il = 0, exp_is = 0, exp_cl = 0, exp_cs = 0;
    bit done = 0;

    typedef struct { int seq; bit st; } iss_item_t;
    iss_item_t exp_q [$];

    function automatic logic [PC_W-1:0] pc_of(int seq);
        return PC_W'(32'h1000 + seq * 16);
    endfunction

    task automatic chk(bit ok, string req, string what, longint act, longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic push(int seq, bit st);
        iss_item_t it;
        it.seq = seq; it.st = st;
        exp_q.push_back(it);
    endtask

    // Scoreboard monitor: compares every fired issue with the expected order
    always begin
        @(negedge clk); #1;
        if (!rst && iss_valid && iss_ready) begin
            if (exp_q.size() == 0) begin
                chk(0, "R3", "unexpected issue seq", longint'(iss_seq), -1);
            end else begin
                iss_item_t it;
                it = exp_q.pop_front();
                chk(iss_seq == SEQ_W'(it.seq), "R3", "issue seq", longint'(iss_seq), it.seq);
                chk(iss_pc == pc_of(it.seq) && iss_is_store == it.st, "R3", "issue pc/type",
                    longint'(iss_pc), longint'(pc_of(it.seq)));
                chk(pred_iss_valid && pred_iss_seq == iss_seq && pred_iss_pc == iss_pc &&
                    pred_iss_store == it.st, "R3", "predictor issue notify",
                    longint'(pred_iss_seq), it.seq);
            end
        end
    end

    task automatic ins(int seq, bit st, bit ops, bit ns, int look, bit acc, bit conf);
        @(negedge clk);
        ins_valid = 1; ins_seq = SEQ_W'(seq); ins_pc = pc_of(seq); ins_is_store = st;
        ins_ops_ready = ops; ins_nonspec = ns; pred_lookup_store = SEQ_W'(look);
        #1;
        chk(pred_lookup_pc == pc_of(seq), "R2", "lookup pc", longint'(pred_lookup_pc), longint'(pc_of(seq)));
        chk(pred_reg_valid == (acc && st), "R6", "register valid", pred_reg_valid, acc && st);
        if (acc && st)
            chk(pred_reg_seq == SEQ_W'(seq) && pred_reg_pc == pc_of(seq), "R6", "register seq",
                longint'(pred_reg_seq), seq);
        if (acc) begin
            if (st) begin exp_is++; if (conf) exp_cs++; end
            else    begin exp_il++; if (conf) exp_cl++; end
        end
        @(posedge clk); #1;
        ins_valid = 0; pred_lookup_store = '0;
    endtask

    task automatic opr(int seq);
        @(negedge clk); opr_valid = 1; opr_seq = SEQ_W'(seq);
        @(posedge clk); #1 opr_valid = 0;
    endtask

    task automatic rel(int seq);
        @(negedge clk); rel_valid = 1; rel_seq = SEQ_W'(seq);
        @(posedge clk); #1 rel_valid = 0;
    endtask

    task automatic squash(int n, int opr_also);
        @(negedge clk);
        sq_valid = 1; sq_seq = SEQ_W'(n);
        if (opr_also != 0) begin opr_valid = 1; opr_seq = SEQ_W'(opr_also); end
        #1;
        chk(pred_sq_valid && pred_sq_seq == SEQ_W'(n), "R8", "squash forward", longint'(pred_sq_seq), n);
        chk(!iss_valid, "R8", "iss_valid in squash", iss_valid, 0);
        chk(full, "R8", "full in squash", full, 1);
        @(posedge clk); #1;
        sq_valid = 0; opr_valid = 0;
    endtask

    task automatic set_ready(bit b);
        @(negedge clk); iss_ready = b;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic look_iss(bit v, int seq, string req);
        @(negedge clk); #1;
        chk(iss_valid == v, req, "iss_valid", iss_valid, v);
        if (v) chk(iss_seq == SEQ_W'(seq), req, "offered seq", longint'(iss_seq), seq);
    endtask

    task automatic check_counts(string req);
        @(negedge clk); #1;
        chk(cnt_ins_loads == CNT_W'(exp_il), req, "cnt_ins_loads", longint'(cnt_ins_loads), exp_il);
        chk(cnt_ins_stores == CNT_W'(exp_is), req, "cnt_ins_stores", longint'(cnt_ins_stores), exp_is);
        chk(cnt_conf_loads == CNT_W'(exp_cl), req, "cnt_conf_loads", longint'(cnt_conf_loads), exp_cl);
        chk(cnt_conf_stores == CNT_W'(exp_cs), req, "cnt_conf_stores", longint'(cnt_conf_stores), exp_cs);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 0;

        // R1: reset state
        @(negedge clk); #1;
        chk(!iss_valid, "R1", "iss_valid after reset", iss_valid, 0);
        chk(!full, "R1", "full after reset", full, 0);
        check_counts("R1");

        // R2, R3, R6: independent entries, oldest first
        ins(1, 0, 1, 0, 0, 1, 0);
        look_iss(1, 1, "R2");
        ins(3, 0, 1, 0, 0, 1, 0);
        ins(2, 1, 1, 0, 0, 1, 0);
        push(1, 0); push(2, 1); push(3, 0);
        set_ready(1); idle(5); set_ready(0);

        // R4, R5: dependents on store 10; 13 predicts an untracked store
        ins(10, 1, 0, 0, 0, 1, 0);
        ins(11, 0, 1, 0, 10, 1, 1);
        ins(12, 0, 0, 0, 10, 1, 1);
        ins(13, 0, 1, 0, 99, 1, 0);
        look_iss(1, 13, "R4");
        push(13, 0);
        set_ready(1); idle(3);
        look_iss(0, 0, "R4");
        opr(77);                                  // R5: unknown seq ignored
        idle(2);
        look_iss(0, 0, "R5");
        push(10, 1); push(11, 0);
        opr(10);
        idle(4);
        look_iss(0, 0, "R4");                     // 12 woken but operands missing
        push(12, 0);
        opr(12);
        idle(3);
        ins(20, 1, 0, 0, 0, 1, 0);
        ins(21, 1, 1, 0, 20, 1, 1);
        push(20, 1); push(21, 1);
        opr(20);
        idle(4);
        check_counts("R10");

        // R7: non-speculative entry waits for release
        ins(30, 0, 1, 1, 0, 1, 0);
        idle(3);
        look_iss(0, 0, "R7");
        opr(30);
        idle(3);
        look_iss(0, 0, "R7");
        push(30, 0);
        rel(30);
        idle(3);

        // R8: squash
        set_ready(0);
        ins(40, 0, 1, 0, 0, 1, 0);
        ins(41, 1, 0, 0, 0, 1, 0);
        ins(42, 0, 1, 0, 41, 1, 1);
        ins(43, 0, 1, 0, 0, 1, 0);
        squash(41, 41);                           // operand notice in squash cycle ignored
        push(40, 0);
        set_ready(1); idle(3);
        look_iss(0, 0, "R8");
        push(41, 1);
        opr(41);
        idle(4);                                  // squashed 42 must not wake
        push(44, 0);
        ins(44, 0, 1, 0, 41, 1, 0);               // R6: issued store no longer tracked
        idle(3);
        ins(50, 1, 0, 0, 0, 1, 0);
        squash(49, 0);
        push(51, 0);
        ins(51, 0, 1, 0, 50, 1, 0);               // R8: squashed store not tracked
        idle(3);
        check_counts("R8");

        // R12: predicted producer issues in the insert cycle
        set_ready(0);
        ins(60, 1, 1, 0, 0, 1, 0);
        push(60, 1); push(61, 0);
        @(negedge clk);
        iss_ready = 1;
        ins_valid = 1; ins_seq = SEQ_W'(61); ins_pc = pc_of(61); ins_is_store = 0;
        ins_ops_ready = 1; ins_nonspec = 0; pred_lookup_store = SEQ_W'(60);
        exp_il++;
        @(posedge clk); #1;
        ins_valid = 0; pred_lookup_store = '0;
        idle(4);
        check_counts("R12");

        // R11: entry capacity and store tracker capacity
        set_ready(0);
        for (int k = 0; k < 16; k++) ins(100 + k, 0, 1, 1, 0, 1, 0);
        @(negedge clk); #1;
        chk(full, "R11", "full with all entries", full, 1);
        ins(200, 0, 1, 0, 0, 0, 0);
        check_counts("R11");
        squash(99, 0);
        @(negedge clk); #1;
        chk(!full, "R11", "full after drain", full, 0);
        for (int k = 0; k < 8; k++) ins(120 + k, 1, 0, 1, 0, 1, 0);
        @(negedge clk); #1;
        chk(full, "R11", "full with all trackers", full, 1);
        ins(128, 0, 1, 0, 0, 0, 0);
        check_counts("R11");
        squash(119, 0);

        // R9: violation forwarding
        @(negedge clk);
        viol_valid = 1; viol_load_pc = 32'hABCD_0010; viol_store_pc = 32'h1234_5670;
        #1;
        chk(pred_viol_valid && pred_viol_load_pc == 32'hABCD_0010, "R9", "viol load pc",
            longint'(pred_viol_load_pc), 32'hABCD_0010);
        chk(pred_viol_store_pc == 32'h1234_5670, "R9", "viol store pc",
            longint'(pred_viol_store_pc), 32'h1234_5670);
        @(posedge clk); #1 viol_valid = 0;

        idle(3);
        chk(exp_q.size() == 0, "R3", "expected issues left", exp_q.size(), 0);
        check_counts("R10");

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule